// File: doc/BRIEF.md
# Vectored Fixed-Priority Interrupt Controller

This block gathers interrupt requests for a small processor core. Two external pins and a set of internal peripheral pulses feed a bank of pending flags. Each source has its own enable bit, and one global enable bit sits on top of all of them. Among the sources that are both pending and enabled, the one with the lowest index wins. The block then presents that source's vector address, which is its table slot counted from a configurable base. Slot zero is held back for reset, so source `i` answers with `VEC_BASE + i + 1`.

The core accepts a request by raising `take`. The block answers with a one-cycle `irq_ack`. In the same step it drops the global enable and clears the serviced source's flag in hardware. A `reti` strobe from the core, issued at the end of the handler, turns the global enable back on. Software writes the enable mask and the pin sense controls, and clears flags by writing ones. Saving the return address and sequencing the core stay outside this block.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, all flags, the enable mask, the global enable, `irq_req` and `irq_ack` are zero, and both pin sense controls are 00.
- R2: With sense 10 a falling pin edge sets the pin's flag, and with sense 11 a rising edge sets it. An edge of the opposite direction sets nothing.
- R3: With sense 00 a low pin requests service for as long as it stays low. It latches no flag, so `flags` bit 0 or 1 stays 0.
- R4: Sense 01 is reserved. The pin then sets no flag and raises no request.
- R5: A one-cycle pulse on `int_pulse[j]` sets flag `N_EXT+j`.
- R6: A flag whose mask bit is 0 stays set but raises no request.
- R7: While the global enable is 0, `irq_req` stays 0 whatever the flags.
- R8: Among pending enabled sources the lowest index wins. `irq_vec` equals `VEC_BASE + index + 1`, and ext0 is index 0.
- R9: Writing `flag_clr_data` with `flag_clr_we` clears each flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R10: A flag that is set in the same cycle as a clear-by-one of that flag stays set.
- R11: `take` while `irq_req` is 1 gives `irq_ack` for one cycle on the next cycle, with `irq_vec` still showing the serviced vector. At that point `gie` is 0, the serviced flag is cleared, other flags are kept and `irq_req` is 0.
- R12: A `reti` strobe sets the global enable. A software write through `gie_we` sets it to `gie_wdata`. A take in the same cycle overrides both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | N_EXT | Asynchronous external interrupt pins |
| int_pulse | input | N_INT | One-cycle set pulses from internal sources |
| sense_we | input | 1 | Write strobe for the sense controls |
| sense_wdata | input | 2*N_EXT | Two bits per pin, pin 0 in bits 1:0 |
| mask_we | input | 1 | Write strobe for the enable mask |
| mask_wdata | input | N_EXT+N_INT | New enable mask |
| flag_clr_we | input | 1 | Write strobe for clearing flags |
| flag_clr_data | input | N_EXT+N_INT | Ones clear the matching flags |
| gie_we | input | 1 | Write strobe for the global enable |
| gie_wdata | input | 1 | New global enable value |
| take | input | 1 | Core accepts the current request |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Registered request to the core |
| irq_vec | output | VEC_W | Vector address of the winning source |
| irq_ack | output | 1 | One-cycle acknowledge of a take |
| gie | output | 1 | Global enable bit |
| flags | output | N_EXT+N_INT | Pending flags |

## Verification
The bench builds the block with `N_INT = 4` and `VEC_BASE = 16`. That gives six sources, so every slot from 17 to 22 can be reached, and an error in the base offset or the reset slot shows up directly in the vectors it checks. With four internal sources, the bench can keep three flags pending at once. It then services them in strict priority order through repeated take and return cycles, and can park a masked source beside an enabled one. Both pins are exercised in all four sense modes, including edges of the wrong direction.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RSV  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/irq_ext_sense.sv
module irq_ext_sense
  import irq_vec_pkg::*;
#(
  parameter int N_EXT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_EXT-1:0]   pin,
  input  logic [2*N_EXT-1:0] sense,
  output logic [N_EXT-1:0]   edge_hit,
  output logic [N_EXT-1:0]   level_req
);
  genvar g;
  generate
    for (g = 0; g < N_EXT; g++) begin : g_pin
      logic s1, s2, prev;
      sense_e mode;
      assign mode = sense_e'(sense[2*g +: 2]);

      // two-stage synchronizer plus one history stage; idle level is high
      always_ff @(posedge clk) begin
        if (rst) begin
          s1   <= 1'b1;
          s2   <= 1'b1;
          prev <= 1'b1;
        end else begin
          s1   <= pin[g];
          s2   <= s1;
          prev <= s2;
        end
      end

      always_comb begin
        edge_hit[g]  = 1'b0;
        level_req[g] = 1'b0;
        case (mode)
          SENSE_LOW:  level_req[g] = !s2;
          SENSE_FALL: edge_hit[g]  = prev && !s2;
          SENSE_RISE: edge_hit[g]  = !prev && s2;
          default:    ;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N_SRC = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] set_vec,
  input  logic [N_SRC-1:0] clr_vec,
  output logic [N_SRC-1:0] flags
);
  // a set in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N_SRC = 6,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] pend,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // scan from the top so the lowest pending index is the last one written
  always_comb begin
    any = |pend;
    idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int N_EXT    = 2,
  parameter int N_INT    = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 0,
  localparam int N_SRC   = N_EXT + N_INT,
  localparam int IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_EXT-1:0]   ext_pin,
  input  logic [N_INT-1:0]   int_pulse,
  input  logic               sense_we,
  input  logic [2*N_EXT-1:0] sense_wdata,
  input  logic               mask_we,
  input  logic [N_SRC-1:0]   mask_wdata,
  input  logic               flag_clr_we,
  input  logic [N_SRC-1:0]   flag_clr_data,
  input  logic               gie_we,
  input  logic               gie_wdata,
  input  logic               take,
  input  logic               reti,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec,
  output logic               irq_ack,
  output logic               gie,
  output logic [N_SRC-1:0]   flags
);
  logic [2*N_EXT-1:0] sense_q;
  logic [N_SRC-1:0]   mask_q;
  logic [N_EXT-1:0]   edge_hit, level_req;
  logic [N_SRC-1:0]   set_vec, clr_vec, hw_clr, pend;
  logic               any;
  logic [IDX_W-1:0]   idx, idx_q;
  logic               take_ok;

  assign take_ok = take && irq_req;

  irq_ext_sense #(.N_EXT(N_EXT)) u_sense (
    .clk(clk), .rst(rst), .pin(ext_pin), .sense(sense_q),
    .edge_hit(edge_hit), .level_req(level_req)
  );

  assign set_vec = {int_pulse, edge_hit};
  assign hw_clr  = take_ok ? (N_SRC'(1) << idx_q) : '0;
  assign clr_vec = (flag_clr_we ? flag_clr_data : '0) | hw_clr;

  irq_flag_bank #(.N_SRC(N_SRC)) u_flags (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec), .flags(flags)
  );

  assign pend = (flags | {{N_INT{1'b0}}, level_req}) & mask_q & {N_SRC{gie}};

  irq_prio_enc #(.N_SRC(N_SRC)) u_prio (
    .pend(pend), .any(any), .idx(idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= '0;
      mask_q  <= '0;
    end else begin
      if (sense_we) sense_q <= sense_wdata;
      if (mask_we)  mask_q  <= mask_wdata;
    end
  end

  // global enable: take beats a software write, which beats a return
  always_ff @(posedge clk) begin
    if (rst)          gie <= 1'b0;
    else if (take_ok) gie <= 1'b0;
    else if (gie_we)  gie <= gie_wdata;
    else if (reti)    gie <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_ack <= 1'b0;
      irq_vec <= '0;
      idx_q   <= '0;
    end else begin
      irq_ack <= take_ok;
      irq_req <= any && !take_ok;
      if (!take_ok) begin
        idx_q   <= idx;
        irq_vec <= VEC_W'(VEC_BASE) + VEC_W'(idx) + VEC_W'(1);
      end
    end
  end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int N_EXT    = 2,
  parameter int N_INT    = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 0
) (
  input logic                   clk,
  input logic                   rst,
  input logic [N_INT-1:0]       int_pulse,
  input logic                   flag_clr_we,
  input logic [N_EXT+N_INT-1:0] flag_clr_data,
  input logic                   gie_we,
  input logic                   take,
  input logic                   reti,
  input logic                   irq_req,
  input logic [VEC_W-1:0]       irq_vec,
  input logic                   irq_ack,
  input logic                   gie,
  input logic [N_EXT+N_INT-1:0] flags
);
  localparam int N_SRC = N_EXT + N_INT;

  p_ack_after_take_r11: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> $past(irq_req && take));

  p_ack_state_r11: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (!gie && !irq_req));

  p_req_gated_r7: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(gie));

  p_vec_range_r8: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec >= VEC_W'(VEC_BASE + 1) && irq_vec <= VEC_W'(VEC_BASE + N_SRC)));

  p_reti_sets_r12: assert property (@(posedge clk) disable iff (rst)
    (reti && !gie_we && !(take && irq_req)) |=> gie);

  genvar g;
  generate
    for (g = 0; g < N_INT; g++) begin : g_int
      p_pulse_sets_r10: assert property (@(posedge clk) disable iff (rst)
        int_pulse[g] |=> flags[N_EXT + g]);
      p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_clr_we && flag_clr_data[N_EXT + g] && !int_pulse[g]) |=> !flags[N_EXT + g]);
    end
  endgenerate
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(
  .N_EXT(N_EXT), .N_INT(N_INT), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk(clk), .rst(rst), .int_pulse(int_pulse), .flag_clr_we(flag_clr_we),
  .flag_clr_data(flag_clr_data), .gie_we(gie_we), .take(take), .reti(reti),
  .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack), .gie(gie), .flags(flags)
);

// File: tb/irq_vec_ctrl_test.sv
module irq_vec_ctrl_test;
  localparam int N_EXT = 2;
  localparam int N_INT = 4;
  localparam int N_SRC = N_EXT + N_INT;
  localparam int VEC_W = 8;
  localparam int BASE  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_EXT-1:0]   ext_pin = '1;
  logic [N_INT-1:0]   int_pulse = '0;
  logic               sense_we = 1'b0;
  logic [2*N_EXT-1:0] sense_wdata = '0;
  logic               mask_we = 1'b0;
  logic [N_SRC-1:0]   mask_wdata = '0;
  logic               flag_clr_we = 1'b0;
  logic [N_SRC-1:0]   flag_clr_data = '0;
  logic               gie_we = 1'b0;
  logic               gie_wdata = 1'b0;
  logic               take = 1'b0;
  logic               reti = 1'b0;
  logic               irq_req, irq_ack, gie;
  logic [VEC_W-1:0]   irq_vec;
  logic [N_SRC-1:0]   flags;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #5 clk = ~clk;

  irq_vec_ctrl #(.N_EXT(N_EXT), .N_INT(N_INT), .VEC_W(VEC_W), .VEC_BASE(BASE)) uut (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .int_pulse(int_pulse),
    .sense_we(sense_we), .sense_wdata(sense_wdata), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .flag_clr_we(flag_clr_we), .flag_clr_data(flag_clr_data),
    .gie_we(gie_we), .gie_wdata(gie_wdata), .take(take), .reti(reti),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack), .gie(gie), .flags(flags)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: every acknowledge must match the next queued vector (R11)
  always @(negedge clk) begin
    if (!rst && irq_ack) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R11 unexpected ack actual=%0d expected=none", irq_vec);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(irq_vec) != e) begin
          n_fail++;
          $display("FAIL R11 ack vector actual=%0d expected=%0d", irq_vec, e);
        end
      end
    end
  end

  task automatic pulse_int(input int j);
    int_pulse[j] = 1'b1;
    tick(1);
    int_pulse = '0;
  endtask

  task automatic do_take(input int vec);
    chk("R11 request before take", int'(irq_req), 1);
    exp_q.push_back(vec);
    take = 1'b1;
    tick(1);
    take = 1'b0;
    chk("R11 gie cleared", int'(gie), 0);
    chk("R11 request dropped", int'(irq_req), 0);
  endtask

  task automatic service(input int vec);
    do_take(vec);
    reti = 1'b1;
    tick(1);
    reti = 1'b0;
    chk("R12 reti sets gie", int'(gie), 1);
    tick(1);
  endtask

  task automatic set_sense(input logic [3:0] v);
    sense_we = 1'b1; sense_wdata = v;
    tick(1);
    sense_we = 1'b0;
  endtask

  task automatic clr_flags(input logic [N_SRC-1:0] v);
    flag_clr_we = 1'b1; flag_clr_data = v;
    tick(1);
    flag_clr_we = 1'b0; flag_clr_data = '0;
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 flags", int'(flags), 0);
    chk("R1 irq_req", int'(irq_req), 0);
    chk("R1 gie", int'(gie), 0);
    chk("R1 irq_ack", int'(irq_ack), 0);

    gie_we = 1'b1; gie_wdata = 1'b1; mask_we = 1'b1; mask_wdata = '1;
    tick(1);
    gie_we = 1'b0; mask_we = 1'b0;
    chk("R12 software write gie", int'(gie), 1);

    // R5 internal source 2
    pulse_int(0);
    chk("R5 flag set", int'(flags), 6'b000100);
    tick(1);
    chk("R8 request", int'(irq_req), 1);
    chk("R8 vector src2", int'(irq_vec), BASE + 3);

    // R11 take
    do_take(BASE + 3);
    chk("R11 served flag cleared", int'(flags), 0);

    // R7 gie off blocks
    pulse_int(1);
    tick(2);
    chk("R7 flag pending", int'(flags[3]), 1);
    chk("R7 no request", int'(irq_req), 0);
    reti = 1'b1;
    tick(1);
    reti = 1'b0;
    chk("R12 gie after reti", int'(gie), 1);
    tick(1);
    chk("R12 request returns", int'(irq_req), 1);
    chk("R8 vector src3", int'(irq_vec), BASE + 4);

    // R8 priority among several pending
    pulse_int(3);
    tick(1);
    chk("R8 src3 beats src5", int'(irq_vec), BASE + 4);
    pulse_int(0);
    tick(1);
    chk("R8 src2 beats src3", int'(irq_vec), BASE + 3);
    service(BASE + 3);
    chk("R11 other flags kept", int'(flags), 6'b101000);
    service(BASE + 4);
    service(BASE + 6);
    chk("R11 all serviced", int'(flags), 0);
    chk("R11 nothing left", int'(irq_req), 0);

    // R6 mask
    mask_we = 1'b1; mask_wdata = 6'b101111;
    tick(1);
    mask_we = 1'b0;
    pulse_int(2);
    tick(2);
    chk("R6 masked flag set", int'(flags[4]), 1);
    chk("R6 masked no request", int'(irq_req), 0);

    // R9 write one to clear
    clr_flags(6'b101111);
    chk("R9 zero leaves flag", int'(flags[4]), 1);
    clr_flags(6'b010000);
    chk("R9 one clears flag", int'(flags[4]), 0);

    // R10 set wins over clear
    int_pulse[2] = 1'b1;
    clr_flags(6'b010000);
    int_pulse = '0;
    chk("R10 set beats clear", int'(flags[4]), 1);
    clr_flags(6'b010000);
    mask_we = 1'b1; mask_wdata = '1;
    tick(1);
    mask_we = 1'b0;

    // R2 edge modes: ext0 falling (10), ext1 rising (11)
    set_sense(4'b1110);
    ext_pin[0] = 1'b0;
    tick(5);
    chk("R2 falling edge flag", int'(flags[0]), 1);
    chk("R8 vector ext0", int'(irq_vec), BASE + 1);
    ext_pin[1] = 1'b0;
    tick(5);
    chk("R2 falling ignored in rise mode", int'(flags[1]), 0);
    ext_pin[1] = 1'b1;
    tick(5);
    chk("R2 rising edge flag", int'(flags[1]), 1);
    service(BASE + 1);
    service(BASE + 2);
    ext_pin[0] = 1'b1;
    tick(5);
    chk("R2 rising ignored in fall mode", int'(flags), 0);

    // R3 low level
    set_sense(4'b1100);
    ext_pin[0] = 1'b0;
    tick(4);
    chk("R3 level request", int'(irq_req), 1);
    chk("R3 level vector", int'(irq_vec), BASE + 1);
    chk("R3 no latched flag", int'(flags[0]), 0);
    ext_pin[0] = 1'b1;
    tick(4);
    chk("R3 release drops request", int'(irq_req), 0);

    // R4 reserved
    set_sense(4'b1101);
    ext_pin[0] = 1'b0;
    tick(4);
    chk("R4 reserved no request", int'(irq_req), 0);
    ext_pin[0] = 1'b1;
    tick(4);
    chk("R4 reserved no flag", int'(flags[0]), 0);

    chk("R11 all acks seen", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule